// File: doc/BRIEF.md
# Shadow Memory Region Decoder

This block decides, for every CPU memory access in the legacy area just below 1 MB, whether the access goes to internal DRAM or to the external bus. The area from C0000h up to FFFFFh is divided into eight 32 KB shadow segments. Each segment can be shadowed on its own. All enabled segments share one read/write attribute pair. A separate switch moves the whole 128 KB video window, A0000h through BFFFFh, into internal memory for both reads and writes.

Three configuration bytes control the block: the segment-enable byte, the attribute byte and the video byte. Each is loaded through a small write port with a two-bit selector. For each request that is offered, the block produces registered read-internal and write-internal flags one cycle later. It also drives two status outputs that report whether the upper, BIOS half of the shadow area (E0000h and above) is served internally for reads or for writes. The DRAM controller and the bus cycles are handled elsewhere.

Top module: `shadow_region_decoder`

## Requirements
- R1: After reset, all three configuration bytes are 00h. Every access is then routed external (both flags low) and both BIOS status outputs are low.
- R2: Segment i covers C0000h + i×8000h through C0000h + i×8000h + 7FFFh, and bit i of the segment-enable byte (selector 0) controls it.
- R3: For an enabled segment, attribute bit 1 (selector 1) set to 1 makes reads internal. Set to 0, it sends reads to the external bus.
- R4: For an enabled segment, attribute bit 0 set to 1 write-protects the shadow copy, so writes go external. Set to 0, it makes writes internal.
- R5: A segment whose enable bit is 0 routes both reads and writes external, whatever the attribute byte holds.
- R6: Video byte (selector 2) bit 2 set to 1 makes reads and writes in A0000h–BFFFFh internal. Set to 0, that range is external. The other video-byte bits have no effect.
- R7: Addresses below A0000h never raise either flag. When no request is offered (req_valid low), both flags are low in the following cycle.
- R8: bios_shadow_rd is high exactly when at least one of segments 4–7 is enabled and attribute bit 1 is 1.
- R9: bios_shadow_wr is high exactly when at least one of segments 4–7 is enabled and attribute bit 0 is 0.
- R10: A configuration write takes effect from the next cycle. A request offered in the same cycle as the write uses the old value. A write with selector 3 changes nothing.
- R11: rd_internal and wr_internal are registered and reflect the request offered one clock earlier. rd_internal can rise only for a read and wr_internal only for a write, so the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Byte selector: 0 segment enable, 1 attribute, 2 video, 3 none |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | A memory request is offered this cycle |
| req_addr | input | 20 | Request byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| rd_internal | output | 1 | Previous request was a read served by internal DRAM |
| wr_internal | output | 1 | Previous request was a write served by internal DRAM |
| bios_shadow_rd | output | 1 | Upper shadow half has internal reads |
| bios_shadow_wr | output | 1 | Upper shadow half has internal writes |

## Verification
The bench probes the first byte, last byte and an interior byte of every segment, and the edges of the video window, 9FFFFh and A0000h. A segment-index calculation that is off by one, or a window compare with the wrong bound, would show up there as a neighbour's route or a lost boundary byte. The attribute byte is swept through all four values, together with segment-enable patterns that alternate and that isolate segments 3 and 4. This catches swapped or inverted attribute bits, and a BIOS status that also counts segments below E0000h. Separate cases cover the following: selector-3 writes, which a loose decoder would apply to a real byte; video bytes with bit 2 clear but other bits set; a configuration write offered in the same cycle as a request, which an unregistered path would apply too early; and idle cycles, which a decoder that ignored req_valid would still flag.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int ADDR_W      = 20;
    localparam int SEG_COUNT   = 8;
    localparam int SEG_SHIFT   = 15;
    localparam int CFG_W       = 8;

    localparam int ATTR_RD_BIT = 1;
    localparam int ATTR_WP_BIT = 0;
    localparam int VIDEO_BIT   = 2;

    typedef enum logic [1:0] {
        SEL_SEG_EN = 2'd0,
        SEL_ATTR   = 2'd1,
        SEL_VIDEO  = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CFG_W-1:0] seg_en;
        logic [CFG_W-1:0] attr;
        logic [CFG_W-1:0] video;
    } shadow_cfg_t;

    typedef struct packed {
        logic rd_int;
        logic wr_int;
    } route_t;

    typedef enum logic [1:0] {
        WIN_OUTSIDE = 2'd0,
        WIN_VIDEO   = 2'd1,
        WIN_SHADOW  = 2'd2
    } window_e;

    function automatic route_t seg_route(input logic enabled, input logic [CFG_W-1:0] attr);
        route_t r;
        r.rd_int = enabled &  attr[ATTR_RD_BIT];
        r.wr_int = enabled & ~attr[ATTR_WP_BIT];
        return r;
    endfunction

    function automatic route_t gate_by_type(input route_t r, input logic valid, input logic is_write);
        route_t g;
        g.rd_int = valid & ~is_write & r.rd_int;
        g.wr_int = valid &  is_write & r.wr_int;
        return g;
    endfunction

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  cfg_sel_e         cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output shadow_cfg_t      cfg
);

    shadow_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_SEG_EN: cfg_q.seg_en <= cfg_wdata;
                SEL_ATTR:   cfg_q.attr   <= cfg_wdata;
                SEL_VIDEO:  cfg_q.video  <= cfg_wdata;
                SEL_NONE:   cfg_q        <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R1
    cfg_reset_zero_chk: assert property (@(posedge clk) $past(rst) |-> (cfg_q == '0));

    // R10
    cfg_sel_none_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_NONE) |=> $stable(cfg_q));

    // R10
    cfg_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/shadow_seg_table.sv
module shadow_seg_table
    import shadow_pkg::*;
#(
    parameter int NSEG      = SEG_COUNT,
    parameter int BIOS_SEG0 = NSEG / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSEG-1:0]  seg_en,
    input  logic [CFG_W-1:0] attr,
    output route_t [NSEG-1:0] routes,
    output logic             bios_rd,
    output logic             bios_wr
);

    localparam int UPPER_N = NSEG - BIOS_SEG0;

    logic [UPPER_N-1:0] upper_rd;
    logic [UPPER_N-1:0] upper_wr;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign routes[s] = seg_route(seg_en[s], attr);
        if (s >= BIOS_SEG0) begin : g_upper
            assign upper_rd[s - BIOS_SEG0] = routes[s].rd_int;
            assign upper_wr[s - BIOS_SEG0] = routes[s].wr_int;
        end
    end

    assign bios_rd = |upper_rd;
    assign bios_wr = |upper_wr;

    // R8
    bios_rd_needs_upper_chk: assert property (@(posedge clk) disable iff (rst)
        bios_rd |-> (seg_en[NSEG-1:BIOS_SEG0] != '0) && attr[ATTR_RD_BIT]);

    // R9
    bios_wr_needs_upper_chk: assert property (@(posedge clk) disable iff (rst)
        bios_wr |-> (seg_en[NSEG-1:BIOS_SEG0] != '0) && !attr[ATTR_WP_BIT]);

    // R5
    disabled_seg_external_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_en == '0) |-> !bios_rd && !bios_wr);

endmodule

// File: rtl/shadow_route.sv
module shadow_route
    import shadow_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int NSEG        = SEG_COUNT,
    parameter int SHIFT       = SEG_SHIFT,
    parameter int VIDEO_BASE  = 'hA0000,
    parameter int SHADOW_BASE = 'hC0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic              video_on,
    input  route_t [NSEG-1:0] routes,
    output logic              rd_internal,
    output logic              wr_internal
);

    localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int EW    = AW + 1;
    localparam logic [EW-1:0] V_LO = EW'(VIDEO_BASE);
    localparam logic [EW-1:0] S_LO = EW'(SHADOW_BASE);
    localparam logic [EW-1:0] S_HI = EW'(SHADOW_BASE + (NSEG << SHIFT));

    logic [EW-1:0]    ext_addr;
    logic [EW-1:0]    offset;
    logic [IDX_W-1:0] seg_idx;
    window_e          win;
    route_t           hit;
    route_t           gated;
    route_t           out_q;

    always_comb begin
        ext_addr = {1'b0, req_addr};
        offset   = ext_addr - S_LO;
        seg_idx  = IDX_W'(offset >> SHIFT);
        if (ext_addr >= V_LO && ext_addr < S_LO)
            win = WIN_VIDEO;
        else if (ext_addr >= S_LO && ext_addr < S_HI)
            win = WIN_SHADOW;
        else
            win = WIN_OUTSIDE;
    end

    always_comb begin
        unique case (win)
            WIN_VIDEO:  hit = '{rd_int: video_on, wr_int: video_on};
            WIN_SHADOW: hit = routes[seg_idx];
            default:    hit = '0;
        endcase
        gated = gate_by_type(hit, req_valid, req_write);
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= gated;
    end

    assign rd_internal = out_q.rd_int;
    assign wr_internal = out_q.wr_int;

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_internal, wr_internal}));

    // R11
    rd_only_for_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rd_internal);

    // R7
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rd_internal && !wr_internal);

    // R7
    low_addr_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_addr < V_LO) |=> !rd_internal && !wr_internal);

    // R6
    video_follows_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && win == WIN_VIDEO) |=> ((rd_internal || wr_internal) == $past(video_on)));

endmodule

// File: rtl/shadow_region_decoder.sv
module shadow_region_decoder
    import shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rd_internal,
    output logic              wr_internal,
    output logic              bios_shadow_rd,
    output logic              bios_shadow_wr
);

    shadow_cfg_t            cfg;
    route_t [SEG_COUNT-1:0] routes;

    shadow_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel_e'(cfg_sel)),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    shadow_seg_table #(
        .NSEG (SEG_COUNT)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .seg_en  (cfg.seg_en[SEG_COUNT-1:0]),
        .attr    (cfg.attr),
        .routes  (routes),
        .bios_rd (bios_shadow_rd),
        .bios_wr (bios_shadow_wr)
    );

    shadow_route #(
        .AW    (ADDR_W),
        .NSEG  (SEG_COUNT),
        .SHIFT (SEG_SHIFT)
    ) u_route (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .video_on    (cfg.video[VIDEO_BIT]),
        .routes      (routes),
        .rd_internal (rd_internal),
        .wr_internal (wr_internal)
    );

endmodule

// File: tb/sim_shadow_region_decoder.sv
module sim_shadow_region_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = 20'h0;
    logic        req_write = 1'b0;
    logic        rd_internal, wr_internal, bios_shadow_rd, bios_shadow_wr;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_en = 8'h00, m_attr = 8'h00, m_vid = 8'h00;

    always #4 clk = ~clk;

    shadow_region_decoder u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rd_internal(rd_internal), .wr_internal(wr_internal),
        .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input int a, input logic w,
                                         input logic [7:0] en, input logic [7:0] at, input logic [7:0] vd);
        logic ri = 1'b0, wi = 1'b0;
        if (a >= 'hA0000 && a < 'hC0000) begin
            ri = vd[2]; wi = vd[2];
        end else if (a >= 'hC0000 && a <= 'hFFFFF) begin
            int s = (a - 'hC0000) / 'h8000;
            if (en[s]) begin ri = at[1]; wi = !at[0]; end
        end
        return {!w && ri, w && wi};
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) m_en = d;
        else if (sel == 2'd1) m_attr = d;
        else if (sel == 2'd2) m_vid = d;
    endtask

    task automatic access(input string req, input int a, input logic w);
        logic [1:0] e;
        req_valid = 1'b1; req_addr = a[19:0]; req_write = w;
        e = model(a, w, m_en, m_attr, m_vid);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, {rd_internal, wr_internal}, e);
    endtask

    task automatic check_status();
        chk("R8 bios_shadow_rd", bios_shadow_rd, (|m_en[7:4]) && m_attr[1]);
        chk("R9 bios_shadow_wr", bios_shadow_wr, (|m_en[7:4]) && !m_attr[0]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] en_list [8];
        logic [7:0] vid_list [3];
        en_list = '{8'h00, 8'hFF, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'h08, 8'h10};
        vid_list = '{8'h00, 8'h04, 8'hFB};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 bios_rd reset", bios_shadow_rd, 0);
        chk("R1 bios_wr reset", bios_shadow_wr, 0);
        access("R1 video read after reset", 'hA0000, 1'b0);
        access("R1 shadow write after reset", 'hF0000, 1'b1);

        // R2 R3 R4 R5 R6 R7 sweep
        foreach (en_list[i]) begin
            for (int at = 0; at < 4; at++) begin
                foreach (vid_list[v]) begin
                    cfg_write(2'd0, en_list[i]);
                    cfg_write(2'd1, 8'(at));
                    cfg_write(2'd2, vid_list[v]);
                    check_status();
                    for (int w = 0; w < 2; w++) begin
                        access("R7 low address", 'h00000, w[0]);
                        access("R7 below video", 'h9FFFF, w[0]);
                        access("R6 video start", 'hA0000, w[0]);
                        access("R6 video mid", 'hB1234, w[0]);
                        access("R6 video end", 'hBFFFF, w[0]);
                        for (int s = 0; s < 8; s++) begin
                            access("R2 seg first byte", 'hC0000 + s * 'h8000, w[0]);
                            access("R3_R4 seg interior", 'hC0000 + s * 'h8000 + 'h4321, w[0]);
                            access("R5 seg last byte", 'hC0000 + s * 'h8000 + 'h7FFF, w[0]);
                        end
                    end
                end
            end
        end

        // R8 R9 exhaustive status over enables and attributes
        for (int e = 0; e < 256; e++) begin
            cfg_write(2'd0, 8'(e));
            for (int at = 0; at < 4; at++) begin
                cfg_write(2'd1, 8'(at | 8'hF0));
                check_status();
            end
        end

        // R10 selector 3 changes nothing
        cfg_write(2'd0, 8'h00);
        cfg_write(2'd1, 8'h02);
        cfg_write(2'd2, 8'h00);
        cfg_write(2'd3, 8'hFF);
        check_status();
        access("R10 sel3 no effect shadow", 'hE0000, 1'b0);
        access("R10 sel3 no effect video", 'hA8000, 1'b1);

        // R10 write in same cycle as request uses old value, new value next cycle
        req_valid = 1'b1; req_addr = 20'hA4000; req_write = 1'b0;
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h04;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R10 same-cycle write uses old video", rd_internal, 0);
        @(negedge clk);
        req_valid = 1'b0;
        m_vid = 8'h04;
        chk("R10 new video applies next cycle", rd_internal, 1);

        // R7 R11 idle cycle gives no flag
        req_valid = 1'b0; req_addr = 20'hA0000; req_write = 1'b0;
        @(negedge clk);
        chk("R7 idle no rd flag", rd_internal, 0);
        chk("R7 idle no wr flag", wr_internal, 0);

        // R11 one-cycle latency, read then write back to back
        req_valid = 1'b1; req_addr = 20'hA0000; req_write = 1'b0;
        @(negedge clk);
        chk("R11 read flag", {rd_internal, wr_internal}, 2'b10);
        req_write = 1'b1;
        @(negedge clk);
        chk("R11 write flag", {rd_internal, wr_internal}, 2'b01);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 flags drop", {rd_internal, wr_internal}, 2'b00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule